// File: doc/BRIEF.md
# Two-Wire Clock-Control Register Target

This block is a target on a two-wire serial bus (I2C). It holds the control word that sets up a set of clock synthesizers. A bus host addresses it with a 7-bit device address. The host loads an internal location pointer and then writes or reads byte locations. Two of those locations form the 16-bit control word, and the block breaks that word out into clock-select and oscillator-tune fields for the clock generation logic nearby.

Both bus lines are sampled with a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter. The block then finds start, repeated-start and stop conditions and the clock edges. It drives the data line only through an open-drain pull-down enable. The pointer steps by one after every data byte, read or written, and wraps within an eight-location space. Only a byte that has been fully received and acknowledged reaches a register.

Top module: `cfg_i2c_target`

## Requirements
- R1: The block acknowledges the 7-bit address 1,0,1,1,S,0,0 (MSB first), where S is the level of `addr_strap`. An address byte of 8'hB0 (write) or 8'hB1 (read) matches when S = 0, and 8'hB8 / 8'hB9 matches when S = 1. The acknowledge is given by pulling SDA low for the whole high phase of the ninth clock.
- R2: A non-matching address byte gets no acknowledge. This includes the general-call byte 8'h00 and the address built with the other strap value. The block then drives nothing and changes nothing until the next start.
- R3: In a write transfer, the byte after the address loads the pointer from its three low bits, and each later byte is stored at the pointer. Location 0 holds control bits 7:0 and location 1 holds bits 15:8. `aud_sel` is bits 3:0, `utl_sel` bits 7:4, `proc_sel` bits 10:8, `osc_coarse` bits 14:11 and `fine_tune_en` bit 15.
- R4: After each data byte, written or read, the pointer increments by one and wraps from location 7 to location 0.
- R5: A data byte cut off by a stop or a repeated start before its acknowledge clock has ended changes no location.
- R6: A read is a write transfer that sets the pointer, then a repeated start and the address with R/W = 1. The block then sends the bytes from the pointer onward, MSB first. A host acknowledge asks for the next byte. A host NACK makes the block release SDA.
- R7: Locations 2 to 7 read as 8'h00 and ignore writes, while their bytes still advance the pointer.
- R8: Reset (active-low, synchronous) clears the control word to 16'h0000 and releases SDA.
- R9: A pulse on SCL shorter than the filter length (FILT_LEN system clocks) is not seen as a bus clock edge.
- R10: The SDA pull-down changes only while the filtered SCL is low. The only exception is a release caused by a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_strap | input | 1 | Board strap that selects address bit 2 |
| sda_pull | output | 1 | When 1, the pad pulls SDA low |
| ctrl_word | output | 16 | Full control word {location 1, location 0} |
| aud_sel | output | 4 | Audio clock select, bits 3:0 |
| utl_sel | output | 4 | Utility clock select, bits 7:4 |
| proc_sel | output | 3 | Processor clock select, bits 10:8 |
| osc_coarse | output | 4 | Oscillator coarse tune, bits 14:11 |
| fine_tune_en | output | 1 | Oscillator fine-tune enable, bit 15 |

## Verification
The hardest cases to reach are transfers that end early. One is a data byte cut off partway by a stop or a repeated start. The other is an SCL spike lasting only one system clock during a data bit. The bench has a bit-level host model in which every SCL and SDA transition is a separate step. This lets a task stop after any bit count, force a condition while SCL is low, or insert a single-cycle SCL pulse. The registers are then read back over the bus, so each of these cases is checked only at the ports.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  localparam int LOC_COUNT  = 8;
  localparam int PTR_W      = $clog2(LOC_COUNT);
  localparam int CTRL_BYTES = 2;
  localparam int CTRL_W     = 8 * CTRL_BYTES;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_PTR,
    ST_ACK_PTR,
    ST_WDATA,
    ST_ACK_W,
    ST_RDATA,
    ST_RACK
  } phase_t;

  // device address: 1 0 1 1 strap 0 0
  function automatic logic addr_hit(input logic [6:0] a, input logic strap);
    return a == {4'b1011, strap, 2'b00};
  endfunction

  function automatic logic [3:0] fld_aud(input logic [CTRL_W-1:0] w);
    return w[3:0];
  endfunction

  function automatic logic [3:0] fld_utl(input logic [CTRL_W-1:0] w);
    return w[7:4];
  endfunction

  function automatic logic [2:0] fld_proc(input logic [CTRL_W-1:0] w);
    return w[10:8];
  endfunction

  function automatic logic [3:0] fld_coarse(input logic [CTRL_W-1:0] w);
    return w[14:11];
  endfunction

  function automatic logic fld_fine(input logic [CTRL_W-1:0] w);
    return w[15];
  endfunction

endpackage

// File: rtl/cfgi2c_line_filter.sv
module cfgi2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_f
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0]       sync_q;
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != filt_q) begin
        if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
          filt_q <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_f = filt_q;

  AST_FILT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(sync_q[1] != filt_q)); // R9

endmodule

// File: rtl/cfgi2c_bus_cond.sv
module cfgi2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic bus_start,
  output logic bus_stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign bus_start = scl_f & scl_d & sda_d & ~sda_f;
  assign bus_stop  = scl_f & scl_d & ~sda_d & sda_f;
  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;

endmodule

// File: rtl/cfgi2c_reg_bank.sv
module cfgi2c_reg_bank
  import cfgi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_loc,
  input  logic [7:0]        wr_data,
  input  logic [PTR_W-1:0]  rd_loc,
  output logic [7:0]        rd_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [7:0] bytes_q [CTRL_BYTES];

  for (genvar g = 0; g < CTRL_BYTES; g++) begin : g_loc
    always_ff @(posedge clk) begin
      if (!rst_n) bytes_q[g] <= 8'h00;
      else if (wr_en && (wr_loc == PTR_W'(g))) bytes_q[g] <= wr_data;
    end
    assign ctrl_q[8*g +: 8] = bytes_q[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < CTRL_BYTES; i++)
      if (rd_loc == PTR_W'(i)) rd_data = bytes_q[i];
  end

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(wr_en)); // R5

endmodule

// File: rtl/cfgi2c_engine.sv
module cfgi2c_engine
  import cfgi2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             addr_strap,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr_q,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             sda_pull_q
);
  phase_t     state_q;
  logic [7:0] shreg_q;
  logic [7:0] tx_q;
  logic [3:0] bitcnt_q;
  logic       rw_q;
  logic       mack_q;

  logic byte_done;
  logic ptr_load;
  logic rd_done;

  assign byte_done = scl_fall && (bitcnt_q == 4'd8);
  assign ptr_load  = byte_done && (state_q == ST_PTR);
  assign rd_done   = byte_done && (state_q == ST_RDATA);
  assign wr_en     = scl_fall && (state_q == ST_ACK_W);
  assign wr_data   = shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      shreg_q    <= 8'h00;
      tx_q       <= 8'h00;
      bitcnt_q   <= 4'd0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_pull_q <= 1'b0;
    end else if (bus_start) begin
      state_q    <= ST_ADDR;
      bitcnt_q   <= 4'd0;
      sda_pull_q <= 1'b0;
    end else if (bus_stop) begin
      state_q    <= ST_IDLE;
      sda_pull_q <= 1'b0;
    end else if (scl_rise) begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          shreg_q  <= {shreg_q[6:0], sda_f};
          bitcnt_q <= bitcnt_q + 4'd1;
        end
        ST_RDATA: bitcnt_q <= bitcnt_q + 4'd1;
        ST_RACK:  mack_q   <= ~sda_f;
        default: ;
      endcase
    end else if (scl_fall) begin
      unique case (state_q)
        ST_ADDR: if (bitcnt_q == 4'd8) begin
          if (addr_hit(shreg_q[7:1], addr_strap)) begin
            rw_q       <= shreg_q[0];
            sda_pull_q <= 1'b1;
            state_q    <= ST_ACK_ADDR;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ACK_ADDR: begin
          bitcnt_q <= 4'd0;
          if (rw_q) begin
            tx_q       <= rd_data;
            sda_pull_q <= ~rd_data[7];
            state_q    <= ST_RDATA;
          end else begin
            sda_pull_q <= 1'b0;
            state_q    <= ST_PTR;
          end
        end
        ST_PTR: if (bitcnt_q == 4'd8) begin
          sda_pull_q <= 1'b1;
          state_q    <= ST_ACK_PTR;
        end
        ST_ACK_PTR, ST_ACK_W: begin
          sda_pull_q <= 1'b0;
          bitcnt_q   <= 4'd0;
          state_q    <= ST_WDATA;
        end
        ST_WDATA: if (bitcnt_q == 4'd8) begin
          sda_pull_q <= 1'b1;
          state_q    <= ST_ACK_W;
        end
        ST_RDATA: begin
          if (bitcnt_q == 4'd8) begin
            sda_pull_q <= 1'b0;
            state_q    <= ST_RACK;
          end else begin
            tx_q       <= {tx_q[6:0], 1'b0};
            sda_pull_q <= ~tx_q[6];
          end
        end
        ST_RACK: begin
          if (mack_q) begin
            tx_q       <= rd_data;
            sda_pull_q <= ~rd_data[7];
            bitcnt_q   <= 4'd0;
            state_q    <= ST_RDATA;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr_q <= '0;
    else if (ptr_load)         ptr_q <= shreg_q[PTR_W-1:0];
    else if (wr_en || rd_done) ptr_q <= ptr_q + PTR_W'(1);
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr_q) && !$past(ptr_load)) |-> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R4
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_q) && !$past(bus_start || bus_stop)) |-> !scl_f); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull_q); // R2
  AST_WRITE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(sda_pull_q)); // R5

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfgi2c_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  output logic              sda_pull,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [3:0]        aud_sel,
  output logic [3:0]        utl_sel,
  output logic [2:0]        proc_sel,
  output logic [3:0]        osc_coarse,
  output logic              fine_tune_en
);
  logic [1:0] raw_lines;
  logic [1:0] filt_lines;
  logic scl_f, sda_f;
  logic bus_start, bus_stop, scl_rise, scl_fall;
  logic [PTR_W-1:0] ptr;
  logic wr_en;
  logic [7:0] wr_data, rd_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    cfgi2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_f (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  cfgi2c_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  cfgi2c_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_f),
    .sda_f      (sda_f),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .addr_strap (addr_strap),
    .rd_data    (rd_data),
    .ptr_q      (ptr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .sda_pull_q (sda_pull)
  );

  cfgi2c_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_loc  (ptr),
    .wr_data (wr_data),
    .rd_loc  (ptr),
    .rd_data (rd_data),
    .ctrl_q  (ctrl_word)
  );

  assign aud_sel      = fld_aud(ctrl_word);
  assign utl_sel      = fld_utl(ctrl_word);
  assign proc_sel     = fld_proc(ctrl_word);
  assign osc_coarse   = fld_coarse(ctrl_word);
  assign fine_tune_en = fld_fine(ctrl_word);

  AST_NO_PULL_IN_RESET_EXIT: assert property (@(posedge clk)
    !rst_n |=> !sda_pull); // R8

endmodule

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic strap = 1'b0;
  logic sda_pull;
  logic [15:0] ctrl_word;
  logic [3:0] aud_sel, utl_sel, osc_coarse;
  logic [2:0] proc_sel;
  logic fine_tune_en;
  wire sda_line = m_sda & ~sda_pull;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_i2c_target u_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_strap(strap), .sda_pull(sda_pull), .ctrl_word(ctrl_word),
    .aud_sel(aud_sel), .utl_sel(utl_sel), .proc_sel(proc_sel),
    .osc_coarse(osc_coarse), .fine_tune_en(fine_tune_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    m_sda = b;
    if (glitch) begin
      wq(Q/2); m_scl = 1'b1; @(negedge clk); m_scl = 1'b0; wq(Q);
    end else wq(Q);
    m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask

  // host sends a byte; acked is 1 only if SDA is low at both ends of the ninth high phase
  task automatic send_byte(input logic [7:0] b, output bit acked, input int glitch_at = -1);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == glitch_at);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(2);
    a1 = ~sda_line; wq(2*Q-3);
    a2 = ~sda_line; @(negedge clk); m_scl = 1'b0; wq(Q);
    acked = a1 & a2;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = ~host_ack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic wr_seq(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1, input int n, input string tag);
    bit a;
    bus_start();
    send_byte(8'hB0, a); chk(a, {tag, " addr ack"}, a, 1);
    send_byte(p, a);     chk(a, {tag, " ptr ack"}, a, 1);
    send_byte(d0, a);    chk(a, {tag, " data ack"}, a, 1);
    if (n > 1) begin send_byte(d1, a); chk(a, {tag, " data2 ack"}, a, 1); end
    bus_stop();
  endtask

  task automatic rd_one(input logic [7:0] p, output logic [7:0] d);
    bit a;
    bus_start(); send_byte(8'hB0, a); send_byte(p, a);
    bus_start(); send_byte(8'hB1, a);
    recv_byte(1'b0, d); bus_stop();
  endtask

  task automatic t_reset();
    chk(ctrl_word == 16'h0, "R8 reset word", ctrl_word, 0);
    chk(sda_pull == 1'b0, "R8 reset pull", sda_pull, 0);
  endtask

  task automatic t_write_fields();
    wr_seq(8'h00, 8'hA5, 8'hBC, 2, "R1 R3");
    chk(ctrl_word == 16'hBCA5, "R3 word", ctrl_word, 16'hBCA5);
    chk(aud_sel == 4'h5, "R3 aud", aud_sel, 5);
    chk(utl_sel == 4'hA, "R3 utl", utl_sel, 4'hA);
    chk(proc_sel == 3'd4, "R3 proc", proc_sel, 4);
    chk(osc_coarse == 4'h7, "R3 coarse", osc_coarse, 7);
    chk(fine_tune_en == 1'b1, "R3 fine", fine_tune_en, 1);
  endtask

  task automatic t_strap();
    bit a;
    strap = 1'b1; wq(4);
    bus_start(); send_byte(8'hB0, a);
    chk(!a, "R2 other strap no ack", a, 0);
    send_byte(8'h00, a); send_byte(8'h11, a);
    chk(!a, "R2 passive after miss", a, 0);
    bus_stop();
    chk(ctrl_word == 16'hBCA5, "R2 word kept", ctrl_word, 16'hBCA5);
    bus_start(); send_byte(8'hB8, a);
    chk(a, "R1 strap=1 address ack", a, 1);
    send_byte(8'h01, a); send_byte(8'h3C, a); bus_stop();
    chk(ctrl_word == 16'h3CA5, "R1 strap write", ctrl_word, 16'h3CA5);
    strap = 1'b0; wq(4);
  endtask

  task automatic t_gencall();
    bit a;
    bus_start(); send_byte(8'h00, a);
    chk(!a, "R2 general call no ack", a, 0);
    send_byte(8'h01, a); send_byte(8'hFF, a);
    chk(!a, "R2 general call passive", a, 0);
    bus_stop();
    chk(ctrl_word == 16'h3CA5, "R2 general call word", ctrl_word, 16'h3CA5);
  endtask

  task automatic t_read_seq();
    bit a;
    logic [7:0] d0, d1;
    bus_start(); send_byte(8'hB0, a); send_byte(8'h00, a);
    bus_start(); send_byte(8'hB1, a);
    chk(a, "R6 read address ack", a, 1);
    recv_byte(1'b1, d0);
    recv_byte(1'b0, d1);
    wq(Q);
    chk(sda_pull == 1'b0, "R6 release after nack", sda_pull, 0);
    bus_stop();
    chk(d0 == 8'hA5, "R6 read loc0", d0, 8'hA5);
    chk(d1 == 8'h3C, "R6 read loc1", d1, 8'h3C);
  endtask

  task automatic t_wrap();
    bit a;
    logic [7:0] d [4];
    wr_seq(8'h07, 8'h11, 8'h22, 2, "R4 wrap write");
    chk(ctrl_word == 16'h3C22, "R4 R7 wrap write", ctrl_word, 16'h3C22);
    bus_start(); send_byte(8'hB0, a); send_byte(8'h06, a);
    bus_start(); send_byte(8'hB1, a);
    for (int i = 0; i < 4; i++) recv_byte(i != 3, d[i]);
    bus_stop();
    chk(d[0] == 8'h00, "R7 loc6 zero", d[0], 0);
    chk(d[1] == 8'h00, "R7 loc7 zero after write", d[1], 0);
    chk(d[2] == 8'h22, "R4 read wrap loc0", d[2], 8'h22);
    chk(d[3] == 8'h3C, "R4 read wrap loc1", d[3], 8'h3C);
  endtask

  task automatic t_abort();
    bit a;
    logic [7:0] d;
    bus_start(); send_byte(8'hB0, a); send_byte(8'h00, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    chk(ctrl_word == 16'h3C22, "R5 stop mid byte", ctrl_word, 16'h3C22);
    bus_start(); send_byte(8'hB0, a); send_byte(8'h01, a);
    for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b0);
    bus_start(); send_byte(8'hB1, a);
    recv_byte(1'b0, d); bus_stop();
    chk(ctrl_word == 16'h3C22, "R5 restart mid byte", ctrl_word, 16'h3C22);
    chk(d == 8'h3C, "R5 pointer kept for read", d, 8'h3C);
  endtask

  task automatic t_glitch();
    bit a;
    logic [7:0] d;
    bus_start(); send_byte(8'hB0, a); send_byte(8'h00, a);
    send_byte(8'h5A, a, 3);
    chk(a, "R9 glitch byte ack", a, 1);
    bus_stop();
    chk(ctrl_word[7:0] == 8'h5A, "R9 glitch filtered", ctrl_word[7:0], 8'h5A);
    rd_one(8'h00, d);
    chk(d == 8'h5A, "R10 read back", d, 8'h5A);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 1'b0; wq(4); rst_n = 1'b1; wq(2);
    chk(ctrl_word == 16'h0, "R8 reset clears", ctrl_word, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    wq(6); rst_n = 1'b1; wq(4);
    t_reset();
    t_write_fields();
    t_strap();
    t_gencall();
    t_read_seq();
    t_wrap();
    t_abort();
    t_glitch();
    t_reset_again();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule